// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer of 512 nine-bit words. It has separate write and read clocks. The write side stores a word when both of its enables are high on a rising write-clock edge. The read side moves the oldest word into a registered output when both read enables are high on a rising read-clock edge. Four active-low flags report the fill level: full, empty, near-full and near-empty. The two "near" thresholds are set by nine-bit offsets. Both offsets reset to 7.

One input pin has two roles, and its level during reset picks which one it takes. If the pin is high during reset, it stays a plain second write enable. If it is low during reset, the block enters load mode. In load mode, driving the pin low turns write accesses into offset loads and read accesses into offset readbacks, both carried on the normal data buses. Offset access walks four byte slots in a fixed order, one slot per access.

The read and write pointers cross between the clock domains as Gray codes through two-flop synchronizers. Each side derives its own flags from its own pointer and the synchronized copy of the other side's pointer.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words leave in the order they were written, without loss, up to 512 stored nine-bit words.
- R2: A word is stored only on a write-clock rising edge where `wr_ena` and `wr_enb_load` are both high; any other combination stores nothing.
- R3: A word is removed and loaded into the output register only on a read-clock rising edge where `rd_ena` and `rd_enb` are both high (and, in load mode, `wr_enb_load` is high).
- R4: `full_n` is low while 512 words are held. A write attempted while full is dropped and leaves the stored contents unchanged. `full_n` returns high after reads are seen by the write side.
- R5: `empty_n` is low while no word is held. A read attempted while empty leaves `rd_data` and the read pointer unchanged.
- R6: `near_full_n` is low when the stored count is at least 512 minus the near-full offset, and high when the free locations exceed that offset.
- R7: `near_empty_n` is low when the stored count is at or below the near-empty offset, and high otherwise.
- R8: Reset drives `rd_data` to 0, `empty_n` and `near_empty_n` low, and `full_n` and `near_full_n` high. It sets both offsets to 7 and returns both offset access indices to slot 0.
- R9: The level of `wr_enb_load` at the last write-clock edge inside reset sets the mode. Low selects load mode and high selects normal mode.
- R10: In load mode, a write-clock edge with `wr_ena` high and `wr_enb_load` low stores into the slot given by a 2-bit index, then advances the index, wrapping from 3 to 0. The slots are:
  - slot 0: near-empty bits 7:0, taken from `wr_data[7:0]`
  - slot 1: near-empty bit 8, taken from `wr_data[0]`
  - slot 2: near-full bits 7:0, taken from `wr_data[7:0]`
  - slot 3: near-full bit 8, taken from `wr_data[0]`

  Such a load does not store a FIFO word.
- R11: In load mode, a read-clock edge with both read enables high and `wr_enb_load` low places the slot at a separate read-side index into the output register, zero-extended to nine bits, then advances that index with wrap. Such a readback does not remove a FIFO word.
- R12: `rd_data` is 0 while `rd_drive` is low, and shows the output register while it is high. `rd_drive` has no effect on reads.
- R13: Each clock-domain pointer, in the Gray code that crosses to the other domain, changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset for both domains |
| wr_clk | input | 1 | Write clock |
| wr_ena | input | 1 | First write enable, active high |
| wr_enb_load | input | 1 | Second write enable, or active-low offset access strobe in load mode |
| wr_data | input | 9 | Write data and offset load data |
| rd_clk | input | 1 | Read clock |
| rd_ena | input | 1 | First read enable, active high |
| rd_enb | input | 1 | Second read enable, active high |
| rd_drive | input | 1 | Output drive; low forces `rd_data` to 0 |
| rd_data | output | 9 | Output register, gated by `rd_drive` |
| full_n | output | 1 | Low when 512 words are held |
| near_full_n | output | 1 | Low when the count reaches 512 minus the near-full offset |
| empty_n | output | 1 | Low when no word is held |
| near_empty_n | output | 1 | Low when the count is at or below the near-empty offset |

## Verification
The properties assume that the offsets change only while the FIFO carries no traffic, because each side reads the other side's offset register without synchronization. They also assume that reset spans at least one write-clock edge, so that the mode is captured. The stimulus holds reset for several cycles of both clocks. It programs and reads back offsets only before it pushes words. After every burst, it waits for the pointer synchronizers to settle before it checks a flag that depends on the other domain.

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DW      = 9,
  parameter int AW      = 9,
  parameter int DEF_OFS = 7
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_ena,
  input  logic          wr_enb_load,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_ena,
  input  logic          rd_enb,
  input  logic          rd_drive,
  output logic [DW-1:0] rd_data,
  output logic          full_n,
  output logic          near_full_n,
  output logic          empty_n,
  output logic          near_empty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int HI_W  = AW - 8;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          ld_mode;
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [AW-1:0] ne_ofs, nf_ofs;
  logic [1:0]    widx, ridx;
  logic [DW-1:0] q;
  logic [PW-1:0] wcnt, rcnt;
  logic          full, empty, ld_sel, wr_go, ld_wr, rd_go, ld_rd;
  logic [PW-1:0] wbin_nx, rbin_nx;

  always_ff @(posedge wr_clk)
    if (!rst_n) ld_mode <= ~wr_enb_load;

  assign ld_sel  = ld_mode & ~wr_enb_load;
  assign wcnt    = wbin - g2b(rg_s2);
  assign rcnt    = g2b(wg_s2) - rbin;
  assign full    = (wcnt == DEPTH_P);
  assign empty   = (rcnt == '0);
  assign wr_go   = wr_ena & wr_enb_load & ~full;
  assign ld_wr   = wr_ena & ld_sel;
  assign ld_rd   = rd_ena & rd_enb & ld_sel;
  assign rd_go   = rd_ena & rd_enb & ~ld_sel & ~empty;
  assign wbin_nx = wbin + 1'b1;
  assign rbin_nx = rbin + 1'b1;

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_go) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      ne_ofs <= AW'(DEF_OFS);
      nf_ofs <= AW'(DEF_OFS);
      widx   <= '0;
    end else if (ld_wr) begin
      case (widx)
        2'd0: ne_ofs[7:0]    <= wr_data[7:0];
        2'd1: ne_ofs[AW-1:8] <= wr_data[HI_W-1:0];
        2'd2: nf_ofs[7:0]    <= wr_data[7:0];
        default: nf_ofs[AW-1:8] <= wr_data[HI_W-1:0];
      endcase
      widx <= widx + 2'd1;
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_go) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      q    <= '0;
      ridx <= '0;
    end else if (ld_rd) begin
      case (ridx)
        2'd0: q <= {{(DW-8){1'b0}}, ne_ofs[7:0]};
        2'd1: q <= {{(DW-HI_W){1'b0}}, ne_ofs[AW-1:8]};
        2'd2: q <= {{(DW-8){1'b0}}, nf_ofs[7:0]};
        default: q <= {{(DW-HI_W){1'b0}}, nf_ofs[AW-1:8]};
      endcase
      ridx <= ridx + 2'd1;
    end else if (rd_go) begin
      q <= mem[rbin[AW-1:0]];
    end

  assign rd_data      = rd_drive ? q : '0;
  assign full_n       = ~full;
  assign empty_n      = ~empty;
  assign near_full_n  = ~(wcnt >= (DEPTH_P - PW'(nf_ofs)));
  assign near_empty_n = ~(rcnt <= PW'(ne_ofs));
endmodule

module dcfifo_pflag_chk #(
  parameter int PW = 10
) (
  input logic          rst_n,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_req,
  input logic          rd_req,
  input logic          ld_wr,
  input logic          full_n,
  input logic          empty_n,
  input logic          near_full_n,
  input logic          near_empty_n,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && wr_req) |=> $stable(wbin)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_req) |=> $stable(rbin)); // R5
  AST_FULL_NEAR: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !near_full_n); // R6
  AST_EMPTY_NEAR: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !near_empty_n); // R7
  AST_LOAD_KEEPS_WPTR: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (ld_wr && !wr_req) |=> $stable(wbin)); // R10
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R13
  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R13
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.PW(PW)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk),
  .wr_req(wr_ena & wr_enb_load),
  .rd_req(rd_ena & rd_enb & ~(ld_mode & ~wr_enb_load)),
  .ld_wr(ld_mode & wr_ena & ~wr_enb_load),
  .full_n(full_n), .empty_n(empty_n),
  .near_full_n(near_full_n), .near_empty_n(near_empty_n),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray));

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/1ps
module sim_dcfifo_pflag;
  logic rst_n = 0, wclk = 0, rclk = 0;
  logic we1 = 0, pin = 1, re1 = 0, re2 = 0, oe = 1;
  logic [8:0] wd = '0;
  logic [8:0] rd_data;
  logic full_n, near_full_n, empty_n, near_empty_n;
  int checks = 0, failures = 0;
  bit done = 0;
  int model[$];

  always #2.5 wclk = ~wclk;
  initial begin #1.3; forever #2.5 rclk = ~rclk; end

  dcfifo_pflag u0 (.rst_n(rst_n), .wr_clk(wclk), .wr_ena(we1), .wr_enb_load(pin),
    .wr_data(wd), .rd_clk(rclk), .rd_ena(re1), .rd_enb(re2), .rd_drive(oe),
    .rd_data(rd_data), .full_n(full_n), .near_full_n(near_full_n),
    .empty_n(empty_n), .near_empty_n(near_empty_n));

  // {wr_ena, wr_enb_load, data}
  localparam logic [10:0] VEC [0:7] = '{
    {1'b1, 1'b1, 9'h055}, {1'b1, 1'b0, 9'h0AA}, {1'b1, 1'b1, 9'h1C3},
    {1'b0, 1'b1, 9'h111}, {1'b1, 1'b1, 9'h000}, {1'b1, 1'b1, 9'h1FF},
    {1'b0, 1'b0, 9'h0F0}, {1'b1, 1'b1, 9'h12E}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic p);
    @(negedge wclk);
    rst_n = 0; pin = p; we1 = 0; re1 = 0; re2 = 0;
    repeat (3) @(negedge wclk);
    rst_n = 1; pin = 1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic wr(input logic a, input logic b, input logic [8:0] d);
    @(negedge wclk); we1 = a; pin = b; wd = d;
    @(negedge wclk); we1 = 0; pin = 1;
  endtask

  task automatic rd(input logic a, input logic b);
    @(negedge rclk); re1 = a; re2 = b;
    @(negedge rclk); re1 = 0; re2 = 0;
  endtask

  task automatic rdl();
    @(negedge rclk); pin = 0; re1 = 1; re2 = 1;
    @(negedge rclk); pin = 1; re1 = 0; re2 = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    @(negedge wclk);
  endtask

  initial begin
    #900000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] last;
    do_reset(1'b1);
    @(negedge rclk);
    chk(rd_data == 0, "R8 rd_data", rd_data, 0);
    chk(empty_n == 0 && near_empty_n == 0, "R8 empty flags", {empty_n, near_empty_n}, 0);
    chk(full_n == 1 && near_full_n == 1, "R8 full flags", {full_n, near_full_n}, 3);

    // R2 / R1 table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][10], VEC[i][9], VEC[i][8:0]);
      if (VEC[i][10] && VEC[i][9]) model.push_back(int'(VEC[i][8:0]));
    end
    settle();
    while (model.size() > 0) begin
      int e;
      e = model.pop_front();
      rd(1, 1);
      chk(rd_data == e[8:0], "R2 R1 order", rd_data, e);
      last = rd_data;
    end
    settle();
    chk(empty_n == 0, "R2 only gated writes stored", empty_n, 0);

    // R3 read enables
    wr(1, 1, 9'h1A5);
    settle();
    rd(1, 0);
    chk(rd_data == last, "R3 ena only", rd_data, last);
    rd(0, 1);
    chk(rd_data == last && empty_n == 1, "R3 enb only", rd_data, last);
    rd(1, 1);
    chk(rd_data == 9'h1A5, "R3 both", rd_data, 9'h1A5);

    // R4 / R6 / R7 / R1 fill and drain with default offsets
    do_reset(1'b1);
    for (int i = 0; i < 504; i++) wr(1, 1, 9'(i));
    chk(near_full_n == 1, "R6 count 504", near_full_n, 1);
    wr(1, 1, 9'd504);
    chk(near_full_n == 0, "R6 count 505", near_full_n, 0);
    for (int i = 505; i < 512; i++) wr(1, 1, 9'(i));
    chk(full_n == 0, "R4 full at 512", full_n, 0);
    wr(1, 1, 9'h0AA);
    chk(full_n == 0, "R4 still full", full_n, 0);
    settle();
    for (int i = 0; i < 512; i++) begin
      rd(1, 1);
      if (i == 0 || i == 255 || i == 511 || rd_data != 9'(i))
        chk(rd_data == 9'(i), "R4 R1 drain order", rd_data, i);
      if (i == 503) chk(near_empty_n == 1, "R7 eight left", near_empty_n, 1);
      if (i == 504) chk(near_empty_n == 0, "R7 seven left", near_empty_n, 0);
    end
    settle();
    chk(full_n == 1 && empty_n == 0, "R4 full clears, empty", {full_n, empty_n}, 2);
    rd(1, 1);
    chk(rd_data == 9'h1FF, "R5 read when empty", rd_data, 9'h1FF);
    wr(1, 1, 9'h033);
    settle();
    rd(1, 1);
    chk(rd_data == 9'h033, "R5 pointer kept", rd_data, 9'h033);

    // R12 output drive
    wr(1, 1, 9'h0C3);
    settle();
    oe = 0;
    rd(1, 1);
    chk(rd_data == 0, "R12 drive low", rd_data, 0);
    oe = 1; #0.5;
    chk(rd_data == 9'h0C3, "R12 drive high", rd_data, 9'h0C3);

    // R9 / R11 / R8 load mode defaults
    do_reset(1'b0);
    rdl(); chk(rd_data == 9'h007, "R11 R8 slot0 default", rd_data, 7);
    rdl(); chk(rd_data == 9'h000, "R11 R8 slot1 default", rd_data, 0);
    rdl(); chk(rd_data == 9'h007, "R11 R8 slot2 default", rd_data, 7);
    rdl(); chk(rd_data == 9'h000, "R11 R8 slot3 default", rd_data, 0);
    chk(empty_n == 0, "R11 readback keeps FIFO", empty_n, 0);

    // R10 loads: near-empty = 3, near-full = 0x1F0
    wr(1, 0, 9'h103);
    wr(1, 0, 9'h002);
    wr(1, 0, 9'h1F0);
    wr(1, 0, 9'h001);
    settle();
    chk(empty_n == 0, "R10 loads store no word", empty_n, 0);
    rdl(); chk(rd_data == 9'h003, "R10 slot0", rd_data, 3);
    rdl(); chk(rd_data == 9'h000, "R10 slot1 bit0 only", rd_data, 0);
    rdl(); chk(rd_data == 9'h0F0, "R10 slot2", rd_data, 9'h0F0);
    rdl(); chk(rd_data == 9'h001, "R10 slot3", rd_data, 1);

    for (int i = 0; i < 3; i++) wr(1, 1, 9'(9'h100 + i));
    settle();
    chk(near_empty_n == 0, "R7 R9 count 3 offset 3", near_empty_n, 0);
    wr(1, 1, 9'h103);
    settle();
    chk(near_empty_n == 1, "R7 count 4 offset 3", near_empty_n, 1);
    for (int i = 4; i < 15; i++) wr(1, 1, 9'(9'h100 + i));
    chk(near_full_n == 1, "R6 count 15 offset 496", near_full_n, 1);
    wr(1, 1, 9'h10F);
    chk(near_full_n == 0, "R6 count 16 offset 496", near_full_n, 0);
    rd(1, 1);
    chk(rd_data == 9'h100, "R9 R3 normal read in load mode", rd_data, 9'h100);

    // R10 wrap of both indices
    wr(1, 0, 9'h005);
    rdl(); chk(rd_data == 9'h005, "R10 R11 wrap", rd_data, 5);

    // R8 index reset
    do_reset(1'b0);
    wr(1, 0, 9'h044);
    rdl(); chk(rd_data == 9'h044, "R8 index reset", rd_data, 9'h044);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule